// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block narrows a 32-bit binary32 floating-point value to a 16-bit binary16 value, placed zero-extended in a 32-bit result word. It returns four exception flags with the result. Finite inputs are rounded to nearest with ties to even. Results too small to be normal are delivered as binary16 subnormals and are not flushed to zero. Infinities keep their sign. NaNs follow a payload rule of their own: the two most significant and the eight least significant input fraction bits are carried over, rather than the top ten.

The converter is one register stage deep. When the enable input `cvt_en` is high at a rising clock edge, the source word is converted and captured. The result, the flags and a valid strobe appear in the following cycle. When `cvt_en` is low, the captured result is kept and the valid strobe drops.

A sticky exception indicator tracks the most recent conversion. It is set when that conversion raised any flag and cleared when it raised none.

A two-state controller sequences the stage:
- `ST_IDLE` means no conversion happened in the last cycle.
- `ST_LOADED` means the output registers hold a result captured at the last edge.
- Transition IDLE→LOADED fires on `cvt_en`, and so does LOADED→LOADED.
- Transitions LOADED→IDLE and IDLE→IDLE fire on `!cvt_en`.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: While and after reset, `res_valid`, `res_bits`, all four flags and `exc_sticky` are 0, and the controller is in `ST_IDLE`.
- R2: With `cvt_en` high at edge N, `res_valid` is 1 after edge N and the result and flags of that source word are present. With `cvt_en` low at edge N, `res_valid` is 0 after it, and `res_bits`, the flags and `exc_sticky` keep their values.
- R3: `res_bits[31:16]` is always 0. The binary16 value sits in `res_bits[15:0]`: sign in bit 15, exponent in [14:10], fraction in [9:0].
- R4: +infinity (0x7F800000) gives 0x7C00 and −infinity (0xFF800000) gives 0xFC00, with no flag raised.
- R5: A NaN source (exponent all ones, fraction nonzero) is converted as follows:
  - result bit 15 is source bit 31 and result [14:10] is all ones;
  - result [9:8] is source [22:21] and result [7:0] is source [7:0];
  - if those ten bits are all zero, result bit 8 is forced to 1.
- R6: A signaling NaN (source bit 22 = 0) raises `flg_invalid`. A quiet NaN (bit 22 = 1) raises no flag. No non-NaN input raises `flg_invalid`.
- R7: Normal results are rounded to nearest, ties to even. `flg_inexact` is 1 exactly when discarded bits were nonzero.
- R8: A magnitude whose rounded value exceeds 65504 gives a signed infinity with `flg_overflow` and `flg_inexact`. This includes a value that only reaches the limit by rounding up.
- R9: Tininess is judged before rounding: the source is tiny when its unbiased exponent is below −14. A tiny, inexact result raises `flg_underflow` and `flg_inexact`, even when rounding carries it to 0x0400. A tiny, exact result raises no flag.
- R10: Source zeros give a signed binary16 zero with no flag. Source subnormals give a signed zero with `flg_underflow` and `flg_inexact`.
- R11: After each conversion, `exc_sticky` is 1 if that conversion raised any flag and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cvt_en | input | 1 | Capture and convert `src_bits` at this edge |
| src_bits | input | 32 | binary32 source word |
| res_valid | output | 1 | A result was captured at the last edge |
| res_bits | output | 32 | Zero-extended binary16 result |
| flg_invalid | output | 1 | Signaling NaN source |
| flg_overflow | output | 1 | Result overflowed to infinity |
| flg_underflow | output | 1 | Tiny before rounding and inexact |
| flg_inexact | output | 1 | Nonzero bits discarded |
| exc_sticky | output | 1 | Last conversion raised any flag |

## Verification
The hardest situations to reach are the ones where rounding crosses a format boundary. One is a tiny value whose rounding carries it into the smallest normal value and must still report underflow. Another is a value at the top of the range whose increment lands on infinity. The stimulus table contains hand-built words that sit exactly on those carries, for example a source with exponent −15 and all-ones upper fraction. It also contains the exact halfway points on both sides of the subnormal threshold. For NaN payloads, a word whose kept bits are zero while dropped middle bits are set exercises the forced bit 8.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int HP_EXP_W = 5;
    localparam int HP_MAN_W = 10;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int HP_W     = 1 + HP_EXP_W + HP_MAN_W;
    localparam int OUT_W    = SP_W;
    localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_BIAS  = (1 << (HP_EXP_W - 1)) - 1;
    // NaN payload split: high bits from the top of the fraction, low bits from the bottom
    localparam int NAN_HI_W = 2;
    localparam int NAN_LO_W = HP_MAN_W - NAN_HI_W;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_TINY,
        CL_FINITE,
        CL_INF,
        CL_NAN
    } fclass_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;

    typedef enum logic {
        ST_IDLE,
        ST_LOADED
    } cvt_state_e;
endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
    import cvt_pkg::*;
#(
    parameter int EXP_W = SP_EXP_W,
    parameter int MAN_W = SP_MAN_W
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output fclass_e          cls_o,
    output logic             snan_o
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    always_comb begin
        if (exp_i == EXP_ONES) begin
            cls_o = (man_i == '0) ? CL_INF : CL_NAN;
        end else if (exp_i == '0) begin
            cls_o = (man_i == '0) ? CL_ZERO : CL_TINY;
        end else begin
            cls_o = CL_FINITE;
        end
    end

    // quiet bit is the fraction MSB; clear means signaling
    assign snan_o = (cls_o == CL_NAN) && !man_i[MAN_W-1];
endmodule

// File: rtl/cvt_nan_pack.sv
module cvt_nan_pack
    import cvt_pkg::*;
#(
    parameter int SM   = SP_MAN_W,
    parameter int HE   = HP_EXP_W,
    parameter int HM   = HP_MAN_W,
    parameter int HI_W = NAN_HI_W,
    parameter int LO_W = NAN_LO_W
) (
    input  logic          sign_i,
    input  logic [SM-1:0] man_i,
    output logic [HE+HM:0] res_o
);
    logic [HM-1:0] payload;

    assign payload = {man_i[SM-1 -: HI_W], man_i[LO_W-1:0]};

    always_comb begin
        res_o = {sign_i, {HE{1'b1}}, payload};
        if (payload == '0) begin
            res_o[LO_W] = 1'b1;
        end
    end
endmodule

// File: rtl/cvt_finite_round.sv
module cvt_finite_round
    import cvt_pkg::*;
#(
    parameter int SE = SP_EXP_W,
    parameter int SM = SP_MAN_W,
    parameter int HE = HP_EXP_W,
    parameter int HM = HP_MAN_W,
    parameter int SB = SP_BIAS,
    parameter int HB = HP_BIAS
) (
    input  logic           sign_i,
    input  logic [SE-1:0]  exp_i,
    input  logic [SM-1:0]  man_i,
    output logic [HE+HM:0] res_o,
    output exc_t           exc_o
);
    localparam int SIG_W  = SM + 1;
    localparam int DROP   = SM - HM;
    localparam int CAP    = SM + 2;
    localparam int SH_W   = $clog2(CAP + 1);
    localparam int XW     = SIG_W + CAP;
    localparam int EW     = SE + 2;
    localparam int HMAX   = (1 << HE) - 1;
    localparam int REBIAS = SB - HB;
    localparam int RW     = HE + HM + 1;

    // destination biased exponent before rounding
    logic signed [EW-1:0] hexp;
    assign hexp = $signed({2'b00, exp_i}) - $signed(EW'(REBIAS));

    // normal path
    logic [HM-1:0] n_keep;
    logic          n_g, n_s, n_up;
    logic [RW-1:0] n_sum;
    assign n_keep = man_i[SM-1 -: HM];
    assign n_g    = man_i[DROP-1];
    assign n_s    = |man_i[DROP-2:0];
    assign n_up   = n_g & (n_s | n_keep[0]);
    assign n_sum  = {1'b0, hexp[HE-1:0], n_keep} + RW'(n_up);

    // subnormal path: align significand to the smallest subnormal weight
    logic signed [EW-1:0] rs_full;
    logic [SH_W-1:0]      rs;
    logic [XW-1:0]        xs;
    logic [SIG_W-1:0]     s_int;
    logic                 s_g, s_s, s_up;
    logic [SIG_W-1:0]     s_sum;
    assign rs_full = $signed(EW'(DROP + 1)) - hexp;
    assign rs      = (rs_full > $signed(EW'(CAP))) ? SH_W'(CAP) : rs_full[SH_W-1:0];
    assign xs      = {1'b1, man_i, {CAP{1'b0}}} >> rs;
    assign s_int   = xs[XW-1:CAP];
    assign s_g     = xs[CAP-1];
    assign s_s     = |xs[CAP-2:0];
    assign s_up    = s_g & (s_s | s_int[0]);
    assign s_sum   = s_int + SIG_W'(s_up);

    always_comb begin
        res_o = '0;
        exc_o = '0;
        if (hexp >= $signed(EW'(HMAX))) begin
            res_o          = {sign_i, {HE{1'b1}}, {HM{1'b0}}};
            exc_o.overflow = 1'b1;
            exc_o.inexact  = 1'b1;
        end else if (hexp > 0) begin
            if (n_sum[HE+HM-1:HM] == {HE{1'b1}}) begin
                res_o          = {sign_i, {HE{1'b1}}, {HM{1'b0}}};
                exc_o.overflow = 1'b1;
                exc_o.inexact  = 1'b1;
            end else begin
                res_o         = {sign_i, n_sum[HE+HM-1:0]};
                exc_o.inexact = n_g | n_s;
            end
        end else begin
            // tiny before rounding; carry into 0x0400 is allowed
            res_o           = {sign_i, s_sum[HE+HM-1:0]};
            exc_o.inexact   = s_g | s_s;
            exc_o.underflow = s_g | s_s;
        end
    end
endmodule

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt
    import cvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cvt_en,
    input  logic [SP_W-1:0]  src_bits,
    output logic             res_valid,
    output logic [OUT_W-1:0] res_bits,
    output logic             flg_invalid,
    output logic             flg_overflow,
    output logic             flg_underflow,
    output logic             flg_inexact,
    output logic             exc_sticky
);
    localparam int PAD_W = OUT_W - HP_W;

    logic                src_sign;
    logic [SP_EXP_W-1:0] src_exp;
    logic [SP_MAN_W-1:0] src_man;
    assign src_sign = src_bits[SP_W-1];
    assign src_exp  = src_bits[SP_W-2 -: SP_EXP_W];
    assign src_man  = src_bits[SP_MAN_W-1:0];

    fclass_e          cls;
    logic             is_snan;
    logic [HP_W-1:0]  nan_res;
    logic [HP_W-1:0]  fin_res;
    exc_t             fin_exc;
    logic [HP_W-1:0]  nx_res;
    exc_t             nx_exc;

    cvt_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) i_class (
        .exp_i  (src_exp),
        .man_i  (src_man),
        .cls_o  (cls),
        .snan_o (is_snan)
    );

    cvt_nan_pack #(
        .SM(SP_MAN_W), .HE(HP_EXP_W), .HM(HP_MAN_W),
        .HI_W(NAN_HI_W), .LO_W(NAN_LO_W)
    ) i_nan (
        .sign_i (src_sign),
        .man_i  (src_man),
        .res_o  (nan_res)
    );

    cvt_finite_round #(
        .SE(SP_EXP_W), .SM(SP_MAN_W), .HE(HP_EXP_W), .HM(HP_MAN_W),
        .SB(SP_BIAS), .HB(HP_BIAS)
    ) i_round (
        .sign_i (src_sign),
        .exp_i  (src_exp),
        .man_i  (src_man),
        .res_o  (fin_res),
        .exc_o  (fin_exc)
    );

    always_comb begin
        nx_res = {src_sign, {(HP_W-1){1'b0}}};
        nx_exc = '0;
        unique case (cls)
            CL_INF: begin
                nx_res = {src_sign, {HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
            end
            CL_NAN: begin
                nx_res         = nan_res;
                nx_exc.invalid = is_snan;
            end
            CL_TINY: begin
                nx_exc.underflow = 1'b1;
                nx_exc.inexact   = 1'b1;
            end
            CL_FINITE: begin
                nx_res = fin_res;
                nx_exc = fin_exc;
            end
            default: begin
                nx_res = {src_sign, {(HP_W-1){1'b0}}};
            end
        endcase
    end

    cvt_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = cvt_en ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_nx = cvt_en ? ST_LOADED : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    logic [HP_W-1:0] res_q;
    exc_t            exc_q;
    logic            sticky_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            exc_q    <= '0;
            sticky_q <= 1'b0;
        end else if (cvt_en) begin
            res_q    <= nx_res;
            exc_q    <= nx_exc;
            sticky_q <= |nx_exc;
        end
    end

    assign res_valid     = (state == ST_LOADED);
    assign res_bits      = {{PAD_W{1'b0}}, res_q};
    assign flg_invalid   = exc_q.invalid;
    assign flg_overflow  = exc_q.overflow;
    assign flg_underflow = exc_q.underflow;
    assign flg_inexact   = exc_q.inexact;
    assign exc_sticky    = sticky_q;
endmodule

// File: rtl/f32_to_f16_cvt_chk.sv
module f32_to_f16_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cvt_en,
    input logic [31:0] src_bits,
    input logic        res_valid,
    input logic [31:0] res_bits,
    input logic        flg_invalid,
    input logic        flg_overflow,
    input logic        flg_underflow,
    input logic        flg_inexact,
    input logic        exc_sticky
);
    p_valid_on_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_en |=> res_valid);

    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cvt_en |=> (!res_valid && $stable(res_bits) && $stable(exc_sticky)));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_bits[31:16] == 16'h0);

    p_inf_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_en && src_bits[30:0] == 31'h7F80_0000)
        |=> (res_bits[14:0] == 15'h7C00 && !flg_invalid && !flg_inexact));

    p_invalid_is_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flg_invalid |-> (res_bits[14:10] == 5'h1F && res_bits[9:0] != 10'h0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flg_overflow |-> (flg_inexact && res_bits[14:0] == 15'h7C00));

    p_underflow_tiny_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flg_underflow |-> (flg_inexact && res_bits[14:0] <= 15'h0400));

    p_sticky_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (exc_sticky ==
            (flg_invalid | flg_overflow | flg_underflow | flg_inexact)));
endmodule

bind f32_to_f16_cvt f32_to_f16_cvt_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cvt_en        (cvt_en),
    .src_bits      (src_bits),
    .res_valid     (res_valid),
    .res_bits      (res_bits),
    .flg_invalid   (flg_invalid),
    .flg_overflow  (flg_overflow),
    .flg_underflow (flg_underflow),
    .flg_inexact   (flg_inexact),
    .exc_sticky    (exc_sticky)
);

// File: tb/test_f32_to_f16_cvt.sv
`timescale 1ns/1ps
module test_f32_to_f16_cvt;
    localparam time CLK_P = 20ns;
    localparam int  NV    = 27;

    // flags packed as {invalid, overflow, underflow, inexact}
    localparam logic [31:0] V_IN [NV] = '{
        32'hFFFF_FFFF, // R5 quiet NaN, all payload kept
        32'hFF80_0000, // R4
        32'h7F80_0000, // R4
        32'h0000_0000, // R10
        32'h34A4_3580, // R9 subnormal 5
        32'h387F_EE74, // R9 rounds up to min normal, still underflow
        32'h7F80_0001, // R6 signaling
        32'h7F90_0000, // R5 payload zero -> bit 8 forced
        32'hFFC0_0000, // R6 quiet
        32'h3F80_0000, // R7
        32'hC000_0000, // R7
        32'h477F_E000, // R8 max finite exact
        32'h477F_F000, // R8 rounds into infinity
        32'h477F_EFFF, // R7 just below overflow
        32'hC7C3_5000, // R8 negative overflow
        32'h3F80_1000, // R7 tie to even (down)
        32'h3F80_3000, // R7 tie to even (up)
        32'h3380_0000, // R9 min subnormal exact
        32'h3300_0000, // R9 half min subnormal tie -> 0
        32'h3340_0000, // R9 above tie -> 1
        32'h3880_0000, // R9 min normal exact
        32'h8000_0001, // R10 negative subnormal
        32'h8000_0000, // R10 negative zero
        32'h7FC0_ABCD, // R5 quiet payload split
        32'hFFA0_0000, // R6 signaling, bit 21 kept
        32'h4780_0000, // R8 exponent beyond range
        32'h4700_0000  // R7 large exact
    };
    localparam logic [15:0] V_OUT [NV] = '{
        16'hFFFF, 16'hFC00, 16'h7C00, 16'h0000, 16'h0005, 16'h0400,
        16'h7C01, 16'h7D00, 16'hFE00, 16'h3C00, 16'hC000, 16'h7BFF,
        16'h7C00, 16'h7BFF, 16'hFC00, 16'h3C00, 16'h3C02, 16'h0001,
        16'h0000, 16'h0001, 16'h0400, 16'h8000, 16'h8000, 16'h7ECD,
        16'hFD00, 16'h7C00, 16'h7800
    };
    localparam logic [3:0] V_FLG [NV] = '{
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 4'b0011,
        4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
        4'b0101, 4'b0001, 4'b0101, 4'b0001, 4'b0001, 4'b0000,
        4'b0011, 4'b0011, 4'b0000, 4'b0011, 4'b0000, 4'b0000,
        4'b1000, 4'b0101, 4'b0000
    };
    localparam int V_REQ [NV] = '{
        5, 4, 4, 10, 9, 9, 6, 5, 6, 7, 7, 8, 8, 7, 8, 7, 7, 9,
        9, 9, 9, 10, 10, 5, 6, 8, 7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cvt_en = 1'b0;
    logic [31:0] src_bits = '0;
    logic        res_valid;
    logic [31:0] res_bits;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;
    logic        exc_sticky;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    f32_to_f16_cvt i_f32_to_f16_cvt (
        .clk           (clk),
        .rst_n         (rst_n),
        .cvt_en        (cvt_en),
        .src_bits      (src_bits),
        .res_valid     (res_valid),
        .res_bits      (res_bits),
        .flg_invalid   (flg_invalid),
        .flg_overflow  (flg_overflow),
        .flg_underflow (flg_underflow),
        .flg_inexact   (flg_inexact),
        .exc_sticky    (exc_sticky)
    );

    function automatic logic [3:0] flags_now();
        return {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge, observe at next negedge
    task automatic convert(input logic [31:0] w);
        @(negedge clk);
        src_bits = w;
        cvt_en   = 1'b1;
        @(negedge clk);
        cvt_en   = 1'b0;
    endtask

    initial begin
        logic [31:0] held;
        logic        held_sticky;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0 && res_bits == 32'h0, "R1", res_bits, 32'h0);
        check(flags_now() == 4'b0 && exc_sticky == 1'b0, "R1",
              {27'h0, flags_now(), exc_sticky}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            convert(V_IN[i]);
            // R3: upper half must be zero, lower is the value
            check(res_bits == {16'h0, V_OUT[i]}, $sformatf("R%0d/R3 result in=%h", V_REQ[i], V_IN[i]),
                  res_bits, {16'h0, V_OUT[i]});
            check(flags_now() == V_FLG[i], $sformatf("R%0d flags in=%h", V_REQ[i], V_IN[i]),
                  {28'h0, flags_now()}, {28'h0, V_FLG[i]});
            check(res_valid == 1'b1, "R2 valid after enable", {31'h0, res_valid}, 32'h1);
            check(exc_sticky == (|V_FLG[i]), "R11 sticky", {31'h0, exc_sticky},
                  {31'h0, |V_FLG[i]});
        end

        // R2 hold: flagged result, then new source without enable
        convert(32'h477F_F000);
        held = res_bits;
        held_sticky = exc_sticky;
        @(negedge clk);
        src_bits = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R2 valid drops", {31'h0, res_valid}, 32'h0);
        check(res_bits == held, "R2 result held", res_bits, held);
        check(flags_now() == 4'b0101 && exc_sticky == held_sticky, "R2 flags held",
              {27'h0, flags_now(), exc_sticky}, {27'h0, 4'b0101, held_sticky});

        // R11 sticky clears on a clean conversion
        convert(32'h3F80_0000);
        check(exc_sticky == 1'b0, "R11 sticky cleared", {31'h0, exc_sticky}, 32'h0);
        convert(32'h0000_0001);
        check(exc_sticky == 1'b1, "R11 sticky set", {31'h0, exc_sticky}, 32'h1);
        check(res_bits == 32'h0, "R10 positive subnormal", res_bits, 32'h0);

        // back-to-back enables: R2 each edge yields its own result
        @(negedge clk);
        src_bits = 32'h3F80_0000;
        cvt_en = 1'b1;
        @(negedge clk);
        check(res_bits == 32'h3C00 && res_valid, "R2 first of burst", res_bits, 32'h3C00);
        src_bits = 32'hC000_0000;
        @(negedge clk);
        check(res_bits == 32'hC000 && res_valid, "R2 second of burst", res_bits, 32'hC000);
        cvt_en = 1'b0;

        // R1 reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0 && res_bits == 32'h0 && exc_sticky == 1'b0 &&
              flags_now() == 4'b0, "R1 reset after use", res_bits, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule